// File: doc/BRIEF.md
# Dual Serial Controller Port

This block gives a processor two readable serial ports for game controllers. Both ports share one strobe register. A write to the strobe register that takes the stored strobe bit from 1 to 0 captures a fresh shift word into each port.

Each shift word holds the button byte of one controller in its lowest byte. The byte above it holds either a fixed signature or, in four-controller mode, the button byte of a second controller. The upper bytes always hold a per-port signature, which marks a position with no device.

Software reads a port one bit at a time. Each read returns the current lowest bit of the word and shifts the word right by one, filling the top with zero. Once every bit has been read out, further reads return zero until the next capture.

Top module: `pad_serial_ports`

## Requirements
- R1: A bus write at address 0 stores write-data bit 0 as the strobe bit. Both ports capture a new shift word only when the stored strobe bit was 1 and the written bit is 0.
- R2: In two-controller mode (`quad_mode`=0), port 0 captures {8'h01, 8'h01, 8'h01, pad 1} and port 1 captures {8'h02, 8'h02, 8'h02, pad 2}. The leftmost byte is byte 3. Pad n occupies `pad_btn` bits 8n-1 down to 8n-8.
- R3: In four-controller mode (`quad_mode`=1), port 0 captures {8'h01, 8'h01, pad 3, pad 1} and port 1 captures {8'h02, 8'h02, pad 4, pad 2}. The mode and the pad inputs are sampled only at the moment of capture.
- R4: A bus read at address 0 reads port 0, and a bus read at address 1 reads port 1. A read returns the selected word's bit 0 on `bus_rdata` bit 0 in the same cycle, then shifts that word right by one with zero fill. The other port's word is left unchanged.
- R5: `bus_rdata` bits 7:1 are always zero, and all of `bus_rdata` is zero in any cycle without a read.
- R6: After all 32 bits of a word have been read, every later read of that port returns 0 until the next capture.
- R7: A bus write at address 1 changes neither the strobe bit nor either shift word.
- R8: Reset clears the strobe bit and both shift words. Reads after reset return 0, and a write of 0 right after reset does not capture.
- R9: A write that leaves the strobe bit unchanged (1 to 1, or 0 to 0) does not capture. Reads made while the strobe is held at 1 shift the previously captured word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = port 0 and strobe register, 1 = port 1 |
| bus_wdata | input | 8 | Write data; bit 0 is the strobe value |
| bus_rdata | output | 8 | Read data; bit 0 is the serial bit |
| quad_mode | input | 1 | 1 selects four-controller capture |
| pad_btn | input | 32 | Four controller button bytes, pad 1 in the low byte |

## Verification
The bench builds the block with its defaults: 8-bit bus, 8-bit pads and a four-byte chain. At these values the full 32-bit word of each port can be read out and checked bit by bit, and the reads past the end of the word are reachable. The vector table covers both modes with patterns that tell a pad byte apart from the signature bytes. Interleaved reads of the two ports show that each port's shifting is independent. Directed sequences cover strobe writes that do not capture, writes at address 1, and the state after reset.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic {
      MODE_DUAL = 1'b0,
      MODE_QUAD = 1'b1
   } pad_mode_e;

   // absent-device marker: one bit set at the port's own index
   function automatic logic [BYTE_W-1:0] absent_mark(input int unsigned port_idx);
      return BYTE_W'(1) << port_idx;
   endfunction
endpackage

// File: rtl/pad_strobe.sv
module pad_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic capture,
   output logic strobe
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     strobe_q <= 1'b0;
      else if (wr_en) strobe_q <= wr_bit;
   end

   assign capture = wr_en & strobe_q & ~wr_bit;
   assign strobe  = strobe_q;

   // R1: a capture always leaves the strobe low
   p_capture_lowers_r1: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> !strobe);
   // R9: with no write the strobe holds
   p_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(strobe));
endmodule

// File: rtl/pad_chain.sv
module pad_chain #(
   parameter int unsigned PAD_W       = 8,
   parameter int unsigned CHAIN_BYTES = 4,
   parameter int unsigned PORT_IDX    = 0,
   localparam int unsigned CHAIN_W    = PAD_W * CHAIN_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             shift,
   input  logic             quad,
   input  logic [PAD_W-1:0] pad_lo,
   input  logic [PAD_W-1:0] pad_hi,
   output logic             bit_out
);
   localparam logic [PAD_W-1:0] MARK = PAD_W'(1) << PORT_IDX;

   logic [CHAIN_W-1:0] word_q;
   logic [CHAIN_W-1:0] load_word;

   assign load_word[PAD_W-1:0]       = pad_lo;
   assign load_word[2*PAD_W-1:PAD_W] = quad ? pad_hi : MARK;

   for (genvar b = 2; b < CHAIN_BYTES; b++) begin : g_mark
      assign load_word[b*PAD_W +: PAD_W] = MARK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '0;
      else if (capture) word_q <= load_word;
      else if (shift)   word_q <= {1'b0, word_q[CHAIN_W-1:1]};
   end

   assign bit_out = word_q[0];

   // R2: the low byte always takes the primary pad at capture
   p_low_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> word_q[PAD_W-1:0] == $past(pad_lo));
   // R3: in quad mode the second byte takes the secondary pad
   p_second_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && quad) |=> word_q[2*PAD_W-1:PAD_W] == $past(pad_hi));
   // R4: a read shifts right with zero fill
   p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !capture) |=> word_q == ($past(word_q) >> 1));
   // R6: an exhausted word stays empty until a capture
   p_empty_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q == '0 && !capture) |=> word_q == '0);
endmodule

// File: rtl/pad_serial_ports.sv
module pad_serial_ports #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAD_W       = 8,
   parameter int unsigned CHAIN_BYTES = 4,
   localparam int unsigned NUM_PADS   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic                      bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic                      quad_mode,
   input  logic [NUM_PADS*PAD_W-1:0] pad_btn
);
   import pad_port_pkg::*;

   if (DATA_W < 1) begin : g_bad_data
      initial $error("DATA_W must be at least 1");
   end
   if (CHAIN_BYTES < 2) begin : g_bad_chain
      initial $error("CHAIN_BYTES must be at least 2");
   end
   if (PAD_W < 2) begin : g_bad_pad
      initial $error("PAD_W must hold both port marks");
   end

   logic       strobe_wr;
   logic       capture;
   logic       strobe;
   logic       rd_en;
   logic [1:0] port_bit;
   pad_mode_e  mode;

   assign mode      = pad_mode_e'(quad_mode);
   assign strobe_wr = bus_sel & bus_wr & ~bus_addr;
   assign rd_en     = bus_sel & ~bus_wr;

   pad_strobe u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (strobe_wr),
      .wr_bit  (bus_wdata[0]),
      .capture (capture),
      .strobe  (strobe)
   );

   for (genvar p = 0; p < 2; p++) begin : g_port
      pad_chain #(
         .PAD_W       (PAD_W),
         .CHAIN_BYTES (CHAIN_BYTES),
         .PORT_IDX    (p)
      ) u_chain (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (capture),
         .shift   (rd_en && (bus_addr == 1'(p))),
         .quad    (mode == MODE_QUAD),
         .pad_lo  (pad_btn[p*PAD_W +: PAD_W]),
         .pad_hi  (pad_btn[(p+2)*PAD_W +: PAD_W]),
         .bit_out (port_bit[p])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en) bus_rdata[0] = port_bit[bus_addr];
   end

   // R5: only bit 0 of read data ever carries information
   always_comb begin
      if (rst_n) p_upper_zero_r5: assert (bus_rdata[DATA_W-1:1] == '0);
   end
   // R7: writes at address 1 leave the strobe alone
   p_addr1_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr) |=> $stable(strobe));
endmodule

// File: tb/pad_serial_ports_tb_top.sv
`timescale 1ns/1ps
module pad_serial_ports_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        quad_mode = 1'b0;
   logic [31:0] pad_btn = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pad_serial_ports dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .quad_mode(quad_mode), .pad_btn(pad_btn)
   );

   // {quad, pads {p4,p3,p2,p1}, expected port0 word, expected port1 word}
   localparam int NVEC = 5;
   localparam logic [96:0] VEC [NVEC] = '{
      {1'b0, 32'h44332211, 32'h01010111, 32'h02020222},
      {1'b1, 32'h44332211, 32'h01013311, 32'h02024422},
      {1'b0, 32'hFFFF00FF, 32'h010101FF, 32'h02020200},
      {1'b1, 32'h8001FE7F, 32'h0101017F, 32'h020280FE},
      {1'b1, 32'h00000000, 32'h01010000, 32'h02020000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic latch();
      bus_write(1'b0, 8'h01);
      bus_write(1'b0, 8'h00);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0]  rd;
      logic [31:0] w0;
      logic [31:0] w1;
      logic [31:0] got0;
      logic [31:0] got1;
      logic [7:0]  upper;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: reset state, reads return zero
      @(negedge clk); #1;
      check("R5 idle read data", 32'(bus_rdata), 32'h0);
      pad_btn = 32'hFFFFFFFF;
      bus_read(1'b0, rd); check("R8 port0 after reset", 32'(rd), 32'h0);
      bus_read(1'b1, rd); check("R8 port1 after reset", 32'(rd), 32'h0);
      bus_write(1'b0, 8'h00);
      bus_read(1'b0, rd); check("R8 write 0 after reset no capture", 32'(rd), 32'h0);

      // table walk: R2, R3, R4, R5, R6
      for (int v = 0; v < NVEC; v++) begin
         quad_mode = VEC[v][96];
         pad_btn   = VEC[v][95:64];
         w0        = VEC[v][63:32];
         w1        = VEC[v][31:0];
         latch();
         quad_mode = ~quad_mode;  // R3: mode sampled only at capture
         pad_btn   = ~pad_btn;
         got0 = '0; got1 = '0; upper = '0;
         for (int b = 0; b < 32; b++) begin
            bus_read(1'b0, rd); got0[b] = rd[0]; upper |= rd & 8'hFE;
            bus_read(1'b1, rd); got1[b] = rd[0]; upper |= rd & 8'hFE;
         end
         check(VEC[v][96] ? "R3 port0 word" : "R2 port0 word", got0, w0);
         check(VEC[v][96] ? "R3 port1 word" : "R2 port1 word", got1, w1);
         check("R5 upper read bits", 32'(upper), 32'h0);
         bus_read(1'b0, rd); check("R6 port0 past end", 32'(rd), 32'h0);
         bus_read(1'b1, rd); check("R6 port1 past end", 32'(rd), 32'h0);
         bus_read(1'b0, rd); check("R6 port0 stays empty", 32'(rd), 32'h0);
      end

      // R4: shifting one port leaves the other untouched
      quad_mode = 1'b0; pad_btn = 32'h0000A5C3;
      latch();
      bus_read(1'b0, rd); check("R4 port0 bit0", 32'(rd), 32'h1);
      bus_read(1'b0, rd); check("R4 port0 bit1", 32'(rd), 32'h1);
      bus_read(1'b0, rd); check("R4 port0 bit2", 32'(rd), 32'h0);
      bus_read(1'b1, rd); check("R4 port1 bit0 unshifted", 32'(rd), 32'h1);
      bus_read(1'b1, rd); check("R4 port1 bit1", 32'(rd), 32'h0);

      // R7: writes at address 1 do not set the strobe
      pad_btn = 32'h000000FF;
      latch();  // strobe now 0, word {01,01,01,FF}
      bus_write(1'b1, 8'h01);
      pad_btn = 32'h00000000;
      bus_write(1'b0, 8'h00);
      bus_read(1'b0, rd); check("R7 addr1 write no strobe", 32'(rd), 32'h1);
      bus_write(1'b0, 8'h01);
      bus_write(1'b1, 8'h00);
      bus_read(1'b0, rd); check("R7 addr1 write no capture", 32'(rd), 32'h1);

      // R9: 1->1 and 0->0 do not capture; reads with strobe high shift old word
      pad_btn = 32'h000000FE;
      bus_write(1'b0, 8'h01);  // 1 -> 1
      bus_read(1'b0, rd); check("R9 read while strobe high shifts old", 32'(rd), 32'h1);
      bus_write(1'b0, 8'h00);  // 1 -> 0: capture FE
      pad_btn = 32'h000000FF;
      bus_write(1'b0, 8'h00);  // 0 -> 0
      bus_read(1'b0, rd); check("R9 0 to 0 no capture", 32'(rd), 32'h0);
      bus_read(1'b0, rd); check("R1 captured on falling strobe", 32'(rd), 32'h1);

      // R1: write data bits other than bit 0 do not act as strobe
      pad_btn = 32'h00000001;
      bus_write(1'b0, 8'hFE);   // stores 0, strobe was 0
      bus_write(1'b0, 8'hFF);
      bus_write(1'b0, 8'hFE);   // 1 -> 0: capture
      bus_read(1'b0, rd); check("R1 capture uses bit 0 only", 32'(rd), 32'h1);
      bus_read(1'b0, rd); check("R1 captured bit1", 32'(rd), 32'h0);

      // R8: reset mid-word clears the word
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_read(1'b1, rd); check("R8 port1 after mid reset", 32'(rd), 32'h0);
      bus_write(1'b0, 8'h00);
      bus_read(1'b1, rd); check("R8 strobe cleared by reset", 32'(rd), 32'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule